// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Counters

This block predicts the next fetch address in the same cycle as the instruction memory read. It holds a small, fully associative set of entries. Each entry stores the word-address tag of a branch, a two-bit saturating direction counter and the branch's target. The fetch stage presents its current PC and gets the next PC back without a clock edge in between. A hit whose counter has its upper bit set steers fetch to the stored target, so a taken branch that is predicted correctly costs no bubble. Every other case falls through to PC+4.

The execute stage sends each resolved branch back through a valid/ready resolution channel. A resolution carries the branch PC, the actual direction, the actual target, and the direction and target that were predicted when the branch was fetched. The block flags a misprediction and supplies the corrected fetch PC in the same cycle. On the clock edge the resolution trains the matching entry. If no entry matches and the branch was taken, the resolution allocates a new entry. The block never applies back-pressure: `res_ready` is permanently high, so every cycle with `res_valid` high counts as an accepted transfer.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses: `pred_taken` is 0 and `next_pc` equals `fetch_pc`+4.
- R2: The lookup is combinational from `fetch_pc` and sees only the table state before the current clock edge. The tag comparison ignores `fetch_pc[1:0]`, so PC values 0x100 and 0x103 match the same entry.
- R3: When a valid entry matches and its counter is 2'b10 or 2'b11, `pred_taken` is 1 and `next_pc` is that entry's target. Otherwise `pred_taken` is 0 and `next_pc` is `fetch_pc`+4.
- R4: A taken resolution whose PC matches no valid entry creates an entry with counter 2'b10 and the resolved target. From the next cycle on, a lookup of that PC predicts taken.
- R5: A not-taken resolution whose PC matches no entry changes nothing, so later lookups of that PC still miss.
- R6: A resolution that matches an entry moves its counter one step: up on taken, saturating at 2'b11, and down on not-taken, saturating at 2'b00.
- R7: A taken resolution that matches an entry replaces the stored target with the resolved target. A not-taken resolution leaves the stored target unchanged.
- R8: An allocation uses the lowest-numbered invalid entry. When all entries are valid, the victim is chosen round-robin, starting at entry 0 and advancing by one with each allocation into a full table.
- R9: `res_mispredict` is 1 during a valid resolution in either of two cases: the predicted direction differs from the actual direction, or both are taken and the predicted target differs from the actual target. `res_redirect_pc` is the actual target for a taken branch and PC+4 for a not-taken branch.
- R10: A resolution whose predicted direction and, when taken, predicted target both match the outcome raises no mispredict. With `res_valid` low, `res_mispredict` is 0.
- R11: `res_ready` is always 1, so a resolution is consumed in every cycle in which `res_valid` is 1.
- R12: No two valid entries ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | PC_W | PC being fetched this cycle |
| next_pc | output | PC_W | Predicted next fetch PC |
| pred_taken | output | 1 | The lookup hit and predicts taken |
| res_valid | input | 1 | A resolved branch is presented |
| res_ready | output | 1 | Always 1; the resolution is accepted |
| res_pc | input | PC_W | PC of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | PC_W | Actual target |
| res_pred_taken | input | 1 | Direction predicted at fetch |
| res_pred_target | input | PC_W | Target predicted at fetch |
| res_mispredict | output | 1 | Redirect and flush required |
| res_redirect_pc | output | PC_W | Correct next PC after the branch |

## Verification
The hardest state to reach from the ports is a full table in which the round-robin pointer has wrapped. Reaching it needs more distinct taken branches than there are entries, and the evictions only show up later as lookups that miss. The stimulus fills all sixteen entries with taken branches at distinct addresses, forces further allocations, and then sweeps lookups across every address, both evicted and retained. A random phase follows. It draws branch addresses from a pool larger than the table and mixes in deliberately wrong predictions, so replacement, counter saturation and target refresh all interleave with simultaneous lookups of the same PC.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

  // Saturating two-bit direction counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? 2'b11 : c + 2'b01;
    else    return (c == 2'b00) ? 2'b00 : c - 2'b01;
  endfunction
endpackage

// File: rtl/btb_entry_array.sv
module btb_entry_array
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PC_W-1:0]    lk_pc,
  input  logic               rs_valid,
  input  logic [PC_W-1:0]    rs_pc,
  input  logic               rs_taken,
  input  logic [PC_W-1:0]    rs_target,
  input  logic [ENTRIES-1:0] alloc_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] lk_hit_vec,
  output logic [ENTRIES-1:0] rs_hit_vec,
  output logic               lk_taken,
  output logic [PC_W-1:0]    lk_target
);
  localparam int TAG_W = PC_W - 2;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [1:0]       ctr_q [ENTRIES];
  logic [PC_W-1:0]  tgt_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  assign valid_vec = vld_q;

  // Parallel tag compare for fetch lookup and for resolution
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_hit_vec[g] = vld_q[g] && (tag_q[g] == lk_pc[PC_W-1:2]);
    assign rs_hit_vec[g] = vld_q[g] && (tag_q[g] == rs_pc[PC_W-1:2]);
  end

  // One-hot read of the hitting entry
  always_comb begin
    lk_taken  = 1'b0;
    lk_target = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i]) begin
        lk_taken  = lk_taken | ctr_q[i][1];
        lk_target = lk_target | tgt_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        ctr_q[i] <= 2'b00;
        tgt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_vec[i]) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= rs_pc[PC_W-1:2];
          ctr_q[i] <= CTR_WEAK_TAKEN;
          tgt_q[i] <= rs_target;
        end else if (rs_valid && rs_hit_vec[i]) begin
          ctr_q[i] <= ctr_step(ctr_q[i], rs_taken);
          if (rs_taken) tgt_q[i] <= rs_target;
        end
      end
    end
  end
endmodule

// File: rtl/btb_victim_sel.sv
module btb_victim_sel #(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               alloc_req,
  output logic [ENTRIES-1:0] alloc_vec
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             full;
  logic [IDX_W-1:0] victim;

  assign full = &valid_vec;

  // Lowest-numbered free slot
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
  end

  assign victim = full ? rr_q : free_idx;

  always_comb begin
    alloc_vec = '0;
    if (alloc_req) alloc_vec[victim] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (alloc_req && full) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
  parameter int PC_W = 32
) (
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_pred_taken,
  input  logic [PC_W-1:0] res_pred_target,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic dir_wrong;
  logic tgt_wrong;

  assign dir_wrong   = res_pred_taken != res_taken;
  assign tgt_wrong   = res_taken && res_pred_taken && (res_pred_target != res_target);
  assign mispredict  = res_valid && (dir_wrong || tgt_wrong);
  assign redirect_pc = res_taken ? res_target : res_pc + STEP;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            pred_taken,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_pred_taken,
  input  logic [PC_W-1:0] res_pred_target,
  output logic            res_mispredict,
  output logic [PC_W-1:0] res_redirect_pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] lk_hit_vec;
  logic [ENTRIES-1:0] rs_hit_vec;
  logic [ENTRIES-1:0] alloc_vec;
  logic               lk_taken;
  logic [PC_W-1:0]    lk_target;
  logic               alloc_req;

  assign res_ready = 1'b1;
  assign alloc_req = res_valid && res_taken && !(|rs_hit_vec);

  btb_entry_array #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_array (
    .clk       (clk),
    .rst       (rst),
    .lk_pc     (fetch_pc),
    .rs_valid  (res_valid),
    .rs_pc     (res_pc),
    .rs_taken  (res_taken),
    .rs_target (res_target),
    .alloc_vec (alloc_vec),
    .valid_vec (valid_vec),
    .lk_hit_vec(lk_hit_vec),
    .rs_hit_vec(rs_hit_vec),
    .lk_taken  (lk_taken),
    .lk_target (lk_target)
  );

  btb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .valid_vec(valid_vec),
    .alloc_req(alloc_req),
    .alloc_vec(alloc_vec)
  );

  btb_resolve #(.PC_W(PC_W)) u_resolve (
    .res_valid      (res_valid),
    .res_pc         (res_pc),
    .res_taken      (res_taken),
    .res_target     (res_target),
    .res_pred_taken (res_pred_taken),
    .res_pred_target(res_pred_target),
    .mispredict     (res_mispredict),
    .redirect_pc    (res_redirect_pc)
  );

  assign pred_taken = lk_taken;
  assign next_pc    = lk_taken ? lk_target : fetch_pc + STEP;
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [PC_W-1:0]    fetch_pc,
  input logic [PC_W-1:0]    next_pc,
  input logic               pred_taken,
  input logic               res_valid,
  input logic               res_taken,
  input logic [PC_W-1:0]    res_target,
  input logic               res_pred_taken,
  input logic [PC_W-1:0]    res_pred_target,
  input logic               res_mispredict,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] lk_hit_vec,
  input logic [ENTRIES-1:0] rs_hit_vec
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: a reset cycle leaves no valid entry behind
  always_ff @(posedge clk) begin
    if (rst_seen) begin
      p_reset_empty_r1: assert (valid_vec == '0);
    end
  end

  // R12
  p_unique_tag_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec) && $onehot0(rs_hit_vec));

  // R3
  p_fallthrough_r3: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> next_pc == fetch_pc + PC_W'(4));

  // R3
  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> (|lk_hit_vec));

  // R5
  p_nt_miss_no_alloc_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_taken && !(|rs_hit_vec) |=> $stable(valid_vec));

  // R4
  p_taken_miss_grows_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_taken && !(|rs_hit_vec) && !(&valid_vec)
    |=> $countones(valid_vec) == $past($countones(valid_vec)) + 1);

  // R9
  p_wrong_dir_flags_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid && (res_pred_taken != res_taken) |-> res_mispredict);

  // R10
  p_correct_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!res_valid || ((res_pred_taken == res_taken) &&
     (!res_taken || res_pred_target == res_target))) |-> !res_mispredict);
endmodule

bind btb_predictor btb_checker #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .fetch_pc       (fetch_pc),
  .next_pc        (next_pc),
  .pred_taken     (pred_taken),
  .res_valid      (res_valid),
  .res_taken      (res_taken),
  .res_target     (res_target),
  .res_pred_taken (res_pred_taken),
  .res_pred_target(res_pred_target),
  .res_mispredict (res_mispredict),
  .valid_vec      (valid_vec),
  .lk_hit_vec     (lk_hit_vec),
  .rs_hit_vec     (rs_hit_vec)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0, next_pc;
  logic        pred_taken;
  logic        res_valid = 1'b0, res_ready;
  logic [31:0] res_pc = '0, res_target = '0, res_pred_target = '0;
  logic        res_taken = 1'b0, res_pred_taken = 1'b0;
  logic        res_mispredict;
  logic [31:0] res_redirect_pc;

  always #10 clk = ~clk;

  btb_predictor #(.ENTRIES(N), .PC_W(32)) dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_taken(pred_taken), .res_valid(res_valid), .res_ready(res_ready),
    .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
    .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
    .res_mispredict(res_mispredict), .res_redirect_pc(res_redirect_pc)
  );

  // Behavioural reference state
  logic        m_v   [N];
  logic [29:0] m_tag [N];
  logic [1:0]  m_ctr [N];
  logic [31:0] m_tgt [N];
  int          m_ptr;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  function automatic int m_find(input logic [31:0] pc);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == pc[31:2]) return i;
    return -1;
  endfunction

  function automatic logic m_ptaken(input logic [31:0] pc);
    int k = m_find(pc);
    return (k >= 0) && m_ctr[k][1];
  endfunction

  function automatic logic [31:0] m_next(input logic [31:0] pc);
    int k = m_find(pc);
    if (k >= 0 && m_ctr[k][1]) return m_tgt[k];
    return pc + 32'd4;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_ctr[i] = 2'b00; m_tgt[i] = '0;
    end
    m_ptr = 0;
  endtask

  task automatic m_update(input logic [31:0] pc, input logic tk, input logic [31:0] tg);
    int k = m_find(pc);
    if (k >= 0) begin
      if (tk) begin
        if (m_ctr[k] != 2'b11) m_ctr[k] = m_ctr[k] + 2'b01;
        m_tgt[k] = tg;
      end else if (m_ctr[k] != 2'b00) begin
        m_ctr[k] = m_ctr[k] - 2'b01;
      end
    end else if (tk) begin
      int slot = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot  = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_v[slot] = 1; m_tag[slot] = pc[31:2]; m_ctr[slot] = 2'b10; m_tgt[slot] = tg;
    end
  endtask

  task automatic check1(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before posedge, advance model at posedge
  task automatic step(input string req, input logic [31:0] fpc, input logic rv,
                      input logic [31:0] rpc, input logic rtk, input logic [31:0] rtg,
                      input logic rptk, input logic [31:0] rptg);
    logic        e_mis;
    logic [31:0] e_red;
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rtk;
    res_target = rtg; res_pred_taken = rptk; res_pred_target = rptg;
    #2;
    e_mis = rv && ((rptk != rtk) || (rtk && rptk && rptg != rtg));
    e_red = rtk ? rtg : rpc + 32'd4;
    check1(req, "next_pc", next_pc, m_next(fpc));
    check1(req, "pred_taken", {31'd0, pred_taken}, {31'd0, m_ptaken(fpc)});
    check1(req, "res_mispredict", {31'd0, res_mispredict}, {31'd0, e_mis});
    check1("R11", "res_ready", {31'd0, res_ready}, 32'd1);
    if (rv) check1(req, "res_redirect_pc", res_redirect_pc, e_red);
    @(posedge clk);
    if (rv) m_update(rpc, rtk, rtg);
  endtask

  task automatic look(input string req, input logic [31:0] fpc);
    step(req, fpc, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  // Resolve using the model's own fetch-time prediction
  task automatic resolve(input string req, input logic [31:0] fpc, input logic [31:0] rpc,
                         input logic rtk, input logic [31:0] rtg);
    logic        pt;
    logic [31:0] pg;
    pt = m_ptaken(rpc);
    pg = m_next(rpc);
    step(req, fpc, 1'b1, rpc, rtk, rtg, pt, pg);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    look("R1", 32'h100);
    look("R1", 32'h0);
    look("R1", 32'hFFFF_FFF0);

    // R4, R9: first taken branch mispredicts and allocates weakly taken
    step("R9", 32'h0, 1'b1, 32'h100, 1'b1, 32'h400, 1'b0, 32'h104);
    look("R4", 32'h100);
    // R2: lookup and resolution of the same PC in one cycle use old state
    resolve("R2", 32'h100, 32'h100, 1'b0, 32'h0);
    look("R2", 32'h103);
    look("R2", 32'h101);

    // R5, R10: not-taken miss is quiet and allocates nothing
    resolve("R10", 32'h0, 32'h200, 1'b0, 32'h0);
    look("R5", 32'h200);

    // R6: walk counter to both saturation points
    resolve("R6", 32'h100, 32'h100, 1'b0, 32'h0);
    look("R6", 32'h100);
    resolve("R6", 32'h100, 32'h100, 1'b0, 32'h0);
    look("R6", 32'h100);
    resolve("R6", 32'h100, 32'h100, 1'b1, 32'h400);
    look("R6", 32'h100);
    resolve("R6", 32'h100, 32'h100, 1'b1, 32'h400);
    resolve("R6", 32'h100, 32'h100, 1'b1, 32'h400);
    resolve("R6", 32'h100, 32'h100, 1'b1, 32'h400);
    resolve("R6", 32'h100, 32'h100, 1'b0, 32'h0);
    look("R6", 32'h100);

    // R7, R9: target change on a predicted-taken branch
    resolve("R9", 32'h100, 32'h100, 1'b1, 32'h800);
    look("R7", 32'h100);
    resolve("R7", 32'h100, 32'h100, 1'b0, 32'h0);
    look("R7", 32'h100);
    // R10: correct taken prediction raises nothing
    resolve("R10", 32'h100, 32'h100, 1'b1, 32'h800);

    // R8: fill the table, then force round-robin replacement
    for (int k = 0; k < 20; k++)
      resolve("R8", 32'h0, 32'h1000 + 32'(k) * 32'h10, 1'b1, 32'h5000 + 32'(k) * 32'h4);
    look("R8", 32'h100);
    for (int k = 0; k < 20; k++) look("R8", 32'h1000 + 32'(k) * 32'h10);
    for (int k = 0; k < 6; k++)
      resolve("R8", 32'h0, 32'h3000 + 32'(k) * 32'h4, 1'b1, 32'h6000);
    for (int k = 0; k < 20; k++) look("R8", 32'h1000 + 32'(k) * 32'h10);

    // R12, R9: random traffic over a pool larger than the table
    for (int c = 0; c < 3000; c++) begin
      logic [31:0] fpc, rpc, tg;
      logic        tk, pt;
      logic [31:0] pg;
      fpc = 32'h2000 + 32'($urandom_range(0, 23)) * 32'h4;
      rpc = 32'h2000 + 32'($urandom_range(0, 23)) * 32'h4;
      tk  = 1'($urandom_range(0, 1));
      tg  = 32'h9000 + 32'($urandom_range(0, 3)) * 32'h4;
      pt  = m_ptaken(rpc);
      pg  = m_next(rpc);
      if ($urandom_range(0, 7) == 0) pt = ~pt;
      if ($urandom_range(0, 3) == 0)
        look("R12", fpc);
      else
        step("R9", fpc, 1'b1, rpc, tk, tg, pt, pg);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule